// File: doc/BRIEF.md
# IOM-2 Terminal Frame Adapter

This block connects a terminal-mode IOM-2 bus to a receiver that works in byte-wide time slots. Each bus frame carries 96 bits in three 32-bit subframes at an 8 kHz rate, which is 768 kbit/s. Inside every subframe the four bytes come in a fixed order: B1, B2, monitor, then the C/I byte with its handshake bits. An external device drives the bus data clock, the frame sync and the downstream data line. The adapter samples all three with its own system clock. The bus data clock runs at twice the bit rate, so the adapter takes exactly one data bit for every two of its rising edges.

The block has two receive modes. In byte mode the frame sync is divided by two, so one receive frame spans two bus frames (192 bits). That frame is cut into 24 slots of 8 bits, MSB first. In nibble mode every bus frame is a receive frame of 24 slots of 4 bits. Each pair of slots is rebuilt into one byte: the first nibble becomes the upper half and the second nibble the lower half. Each finished byte comes out with a one-cycle valid, its slot index and a channel-kind tag. The block also drives a half-rate bit clock and a one-cycle frame strobe.

Top module: `iom_term_adapter`

## Requirements
- R1: While reset is asserted and until the first frame start, `byte_valid_o`, `frame_o` and `bit_clk_o` are low.
- R2: A frame divider toggles on every rising edge of `fsc_i`. In byte mode a frame starts only on an edge that returns the divider to phase 0, so the first `fsc_i` edge after reset starts nothing and yields no bytes.
- R3: Inside an active frame, `bit_clk_o` toggles on every rising edge of `dcl_i` and is low at frame start. One data bit is sampled on each second edge, so a byte-mode frame shows exactly 192 rising edges of `bit_clk_o`.
- R4: In byte mode a frame yields 24 bytes on slots 0 to 23, in order. Each byte is assembled MSB first and is presented with `byte_valid_o` high for exactly one cycle.
- R5: `kind_o` tags each byte by its position within a subframe: 0 = B1, 1 = B2, 2 = monitor, 3 = C/I. This equals the output slot index modulo 4.
- R6: In nibble mode every rising edge of `fsc_i` starts a frame of 24 four-bit slots. Slots 2k and 2k+1 form one byte: the first nibble goes in bits 7:4 and the second in bits 3:0. The byte is output with slot index k (0 to 11).
- R7: The mode input is captured only at a frame start. The captured mode also decides whether the next `fsc_i` edge qualifies as a start. A change of `nibble_mode_i` inside a frame does not affect that frame.
- R8: After the last slot of a frame, further data bits produce no output until the next frame start.
- R9: A qualifying `fsc_i` edge in the middle of a frame restarts at slot 0 and bit 0. The partially received slot is discarded.
- R10: `frame_o` pulses for exactly one cycle on each frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `dcl_i` |
| rst_n | input | 1 | Active-low asynchronous reset |
| dcl_i | input | 1 | Bus data clock at twice the bit rate |
| fsc_i | input | 1 | Bus frame sync, 8 kHz |
| dd_i | input | 1 | Downstream serial data |
| nibble_mode_i | input | 1 | 0 = byte mode, 1 = nibble mode |
| bit_clk_o | output | 1 | Half-rate bit clock |
| frame_o | output | 1 | One-cycle frame start strobe |
| byte_valid_o | output | 1 | One-cycle valid for `byte_o` |
| byte_o | output | 8 | Received byte |
| slot_o | output | 5 | Slot index of `byte_o` |
| kind_o | output | 2 | Channel kind of `byte_o` |

## Verification
The divider phase and the captured mode are invisible at the ports, yet together they decide whether an `fsc_i` edge starts a frame. The hardest cases are therefore a mode switch at a divided-frame boundary and a restart in the middle of a frame. The bench reaches them by sending bus frames of shortened length, with or without a sync edge, and by flipping the mode between bus frames. It tracks the divider parity and the captured mode in its own model, so it knows which edges must start a frame and which bits must be thrown away.

// File: rtl/iom_pkg.sv
package iom_pkg;
   typedef enum logic [1:0] {
      CH_B1  = 2'd0,
      CH_B2  = 2'd1,
      CH_MON = 2'd2,
      CH_CI  = 2'd3
   } ch_kind_e;

   typedef enum logic {
      MODE_BYTE   = 1'b0,
      MODE_NIBBLE = 1'b1
   } rx_mode_e;
endpackage

// File: rtl/iom_sync.sv
module iom_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("iom_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/iom_frame_ctl.sv
module iom_frame_ctl
   import iom_pkg::*;
#(
   parameter bit ENABLE_NIBBLE = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fsc_i,
   input  rx_mode_e mode_req_i,
   output logic     frame_start_o,
   output rx_mode_e mode_o
);
   logic     fsc_prev_q;
   logic     phase_q;
   logic     start_q;
   rx_mode_e mode_q;
   rx_mode_e mode_sel;
   logic     every_edge;
   logic     fsc_rise;
   logic     qualify;

   generate
      if (ENABLE_NIBBLE) begin : g_dual_mode
         assign mode_sel   = mode_req_i;
         assign every_edge = (mode_q == MODE_NIBBLE);
      end else begin : g_byte_only
         assign mode_sel   = MODE_BYTE;
         assign every_edge = 1'b0;
      end
   endgenerate

   assign fsc_rise = fsc_i & ~fsc_prev_q;
   assign qualify  = fsc_rise & (phase_q | every_edge);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsc_prev_q <= 1'b0;
         phase_q    <= 1'b0;
         start_q    <= 1'b0;
         mode_q     <= MODE_BYTE;
      end else begin
         fsc_prev_q <= fsc_i;
         start_q    <= qualify;
         if (fsc_rise) begin
            phase_q <= ~phase_q;
         end
         if (qualify) begin
            mode_q <= mode_sel;
         end
      end
   end

   assign frame_start_o = start_q;
   assign mode_o        = mode_q;
endmodule

// File: rtl/iom_bit_timer.sv
module iom_bit_timer
   import iom_pkg::*;
#(
   parameter int SLOTS     = 24,
   parameter int BYTE_BITS = 8,
   parameter int NIB_BITS  = 4,
   localparam int SLOT_W   = $clog2(SLOTS),
   localparam int BIT_W    = $clog2(BYTE_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dcl_i,
   input  logic              frame_start_i,
   input  rx_mode_e          mode_i,
   output logic              bit_clk_o,
   output logic              sample_o,
   output logic              slot_done_o,
   output logic [SLOT_W-1:0] slot_idx_o
);
   localparam logic [BIT_W-1:0]  BYTE_LAST = BIT_W'(BYTE_BITS - 1);
   localparam logic [BIT_W-1:0]  NIB_LAST  = BIT_W'(NIB_BITS - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

   logic              dcl_prev_q;
   logic              active_q;
   logic              half_q;
   logic [BIT_W-1:0]  bit_q;
   logic [SLOT_W-1:0] slot_q;
   logic              step;
   logic              sample;
   logic              slot_done;
   logic [BIT_W-1:0]  last_bit;

   assign step      = dcl_i & ~dcl_prev_q & active_q;
   assign sample    = step & half_q;
   assign last_bit  = (mode_i == MODE_NIBBLE) ? NIB_LAST : BYTE_LAST;
   assign slot_done = sample & (bit_q == last_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcl_prev_q <= 1'b0;
         active_q   <= 1'b0;
         half_q     <= 1'b0;
         bit_q      <= '0;
         slot_q     <= '0;
      end else begin
         dcl_prev_q <= dcl_i;
         if (frame_start_i) begin
            active_q <= 1'b1;
            half_q   <= 1'b0;
            bit_q    <= '0;
            slot_q   <= '0;
         end else if (step) begin
            half_q <= ~half_q;
            if (slot_done) begin
               bit_q <= '0;
               if (slot_q == SLOT_LAST) begin
                  slot_q   <= '0;
                  active_q <= 1'b0;
               end else begin
                  slot_q <= SLOT_W'(slot_q + 1'b1);
               end
            end else if (sample) begin
               bit_q <= BIT_W'(bit_q + 1'b1);
            end
         end
      end
   end

   assign bit_clk_o   = half_q;
   assign sample_o    = sample;
   assign slot_done_o = slot_done;
   assign slot_idx_o  = slot_q;
endmodule

// File: rtl/iom_slot_asm.sv
module iom_slot_asm
   import iom_pkg::*;
#(
   parameter int BYTE_BITS     = 8,
   parameter int NIB_BITS      = 4,
   parameter int SLOT_W        = 5,
   parameter bit ENABLE_NIBBLE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_start_i,
   input  rx_mode_e             mode_i,
   input  logic                 sample_i,
   input  logic                 bit_i,
   input  logic                 slot_done_i,
   input  logic [SLOT_W-1:0]    slot_idx_i,
   output logic                 valid_o,
   output logic [BYTE_BITS-1:0] data_o,
   output logic [SLOT_W-1:0]    slot_o,
   output ch_kind_e             kind_o
);
   generate
      if (BYTE_BITS != 2 * NIB_BITS) begin : g_bad_widths
         $error("iom_slot_asm: BYTE_BITS must be twice NIB_BITS");
      end
   endgenerate

   logic [BYTE_BITS-1:0] shift_q;
   logic [BYTE_BITS-1:0] word;
   logic                 nib_emit;
   logic [BYTE_BITS-1:0] nib_data;
   logic [SLOT_W-1:0]    nib_slot;
   logic                 emit;
   logic [BYTE_BITS-1:0] out_data;
   logic [SLOT_W-1:0]    out_slot;
   ch_kind_e             kind_cnt_q;
   logic                 byte_mode;

   assign word      = {shift_q[BYTE_BITS-2:0], bit_i};
   assign byte_mode = (mode_i == MODE_BYTE);

   generate
      if (ENABLE_NIBBLE) begin : g_pairing
         logic [NIB_BITS-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q <= '0;
            end else if (frame_start_i) begin
               hi_q <= '0;
            end else if (slot_done_i && !byte_mode && !slot_idx_i[0]) begin
               hi_q <= word[NIB_BITS-1:0];
            end
         end
         assign nib_emit = slot_done_i & slot_idx_i[0];
         assign nib_data = {hi_q, word[NIB_BITS-1:0]};
         assign nib_slot = slot_idx_i >> 1;
      end else begin : g_no_pairing
         assign nib_emit = 1'b0;
         assign nib_data = '0;
         assign nib_slot = '0;
      end
   endgenerate

   assign emit     = byte_mode ? slot_done_i : nib_emit;
   assign out_data = byte_mode ? word        : nib_data;
   assign out_slot = byte_mode ? slot_idx_i  : nib_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q    <= '0;
         valid_o    <= 1'b0;
         data_o     <= '0;
         slot_o     <= '0;
         kind_o     <= CH_B1;
         kind_cnt_q <= CH_B1;
      end else begin
         valid_o <= emit & ~frame_start_i;
         if (sample_i) begin
            shift_q <= word;
         end
         if (frame_start_i) begin
            kind_cnt_q <= CH_B1;
         end else if (emit) begin
            data_o     <= out_data;
            slot_o     <= out_slot;
            kind_o     <= kind_cnt_q;
            kind_cnt_q <= ch_kind_e'(kind_cnt_q + 2'd1);
         end
      end
   end
endmodule

// File: rtl/iom_term_adapter.sv
module iom_term_adapter
   import iom_pkg::*;
#(
   parameter int SYNC_STAGES   = 2,
   parameter int SLOTS         = 24,
   parameter int BYTE_BITS     = 8,
   parameter int NIB_BITS      = 4,
   parameter bit ENABLE_NIBBLE = 1'b1,
   localparam int SLOT_W       = $clog2(SLOTS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 dcl_i,
   input  logic                 fsc_i,
   input  logic                 dd_i,
   input  logic                 nibble_mode_i,
   output logic                 bit_clk_o,
   output logic                 frame_o,
   output logic                 byte_valid_o,
   output logic [BYTE_BITS-1:0] byte_o,
   output logic [SLOT_W-1:0]    slot_o,
   output logic [1:0]           kind_o
);
   generate
      if (SLOTS % 4 != 0) begin : g_bad_slots
         $error("iom_term_adapter: SLOTS must be a multiple of 4");
      end
   endgenerate

   logic [2:0]        bus_s;
   logic              dcl_s;
   logic              fsc_s;
   logic              dd_s;
   rx_mode_e          mode_req;
   rx_mode_e          mode_cur;
   logic              frame_start;
   logic              sample;
   logic              slot_done;
   logic [SLOT_W-1:0] slot_idx;
   ch_kind_e          kind;

   iom_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({dcl_i, fsc_i, dd_i}),
      .q_o   (bus_s)
   );

   assign dcl_s    = bus_s[2];
   assign fsc_s    = bus_s[1];
   assign dd_s     = bus_s[0];
   assign mode_req = nibble_mode_i ? MODE_NIBBLE : MODE_BYTE;

   iom_frame_ctl #(.ENABLE_NIBBLE(ENABLE_NIBBLE)) u_frame (
      .clk           (clk),
      .rst_n         (rst_n),
      .fsc_i         (fsc_s),
      .mode_req_i    (mode_req),
      .frame_start_o (frame_start),
      .mode_o        (mode_cur)
   );

   iom_bit_timer #(
      .SLOTS     (SLOTS),
      .BYTE_BITS (BYTE_BITS),
      .NIB_BITS  (NIB_BITS)
   ) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .dcl_i         (dcl_s),
      .frame_start_i (frame_start),
      .mode_i        (mode_cur),
      .bit_clk_o     (bit_clk_o),
      .sample_o      (sample),
      .slot_done_o   (slot_done),
      .slot_idx_o    (slot_idx)
   );

   iom_slot_asm #(
      .BYTE_BITS     (BYTE_BITS),
      .NIB_BITS      (NIB_BITS),
      .SLOT_W        (SLOT_W),
      .ENABLE_NIBBLE (ENABLE_NIBBLE)
   ) u_asm (
      .clk           (clk),
      .rst_n         (rst_n),
      .frame_start_i (frame_start),
      .mode_i        (mode_cur),
      .sample_i      (sample),
      .bit_i         (dd_s),
      .slot_done_i   (slot_done),
      .slot_idx_i    (slot_idx),
      .valid_o       (byte_valid_o),
      .data_o        (byte_o),
      .slot_o        (slot_o),
      .kind_o        (kind)
   );

   assign frame_o = frame_start;
   assign kind_o  = kind;
endmodule

// File: rtl/iom_term_adapter_chk.sv
module iom_term_adapter_chk #(
   parameter int SLOTS  = 24,
   parameter int SLOT_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_o,
   input logic              byte_valid_o,
   input logic [SLOT_W-1:0] slot_o,
   input logic [1:0]        kind_o
);
   logic [SLOT_W-1:0] exp_slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_slot_q <= '0;
      end else if (frame_o) begin
         exp_slot_q <= '0;
      end else if (byte_valid_o) begin
         exp_slot_q <= SLOT_W'(exp_slot_q + 1'b1);
      end
   end

   a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |=> !byte_valid_o);

   a_r10_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o |=> !frame_o);

   a_r4_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |-> slot_o == exp_slot_q);

   a_r5_kind_tag: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |-> kind_o == slot_o[1:0]);

   a_r6_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o |-> slot_o < SLOT_W'(SLOTS));

   a_r9_no_stale_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      frame_o |=> !byte_valid_o);
endmodule

bind iom_term_adapter iom_term_adapter_chk #(
   .SLOTS  (SLOTS),
   .SLOT_W (SLOT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_o      (frame_o),
   .byte_valid_o (byte_valid_o),
   .slot_o       (slot_o),
   .kind_o       (kind_o)
);

// File: tb/tb_iom_term_adapter.sv
module tb_iom_term_adapter;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       dcl_i, fsc_i, dd_i, nibble_mode_i;
   logic       bit_clk_o, frame_o, byte_valid_o;
   logic [7:0] byte_o;
   logic [4:0] slot_o;
   logic [1:0] kind_o;

   always #5 clk = ~clk;

   iom_term_adapter dut (
      .clk(clk), .rst_n(rst_n), .dcl_i(dcl_i), .fsc_i(fsc_i), .dd_i(dd_i),
      .nibble_mode_i(nibble_mode_i), .bit_clk_o(bit_clk_o), .frame_o(frame_o),
      .byte_valid_o(byte_valid_o), .byte_o(byte_o), .slot_o(slot_o), .kind_o(kind_o)
   );

   int checks = 0;
   int errors = 0;
   int act_q[$];
   int exp_q[$];
   int frames_seen = 0;
   int bitclk_rises = 0;
   logic prev_valid = 1'b0;
   logic prev_bclk = 1'b0;

   // reference model state
   bit m_phase, m_modeq, m_active, m_mode;
   int m_slot, m_bit, m_sr, m_hi, m_starts;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int pack_ent(input int slot, input int data, input int kind);
      return (slot << 12) | ((data & 8'hFF) << 4) | (kind & 3);
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (byte_valid_o) act_q.push_back(pack_ent(int'(slot_o), int'(byte_o), int'(kind_o)));
         if (byte_valid_o && prev_valid) chk(1'b0, "R4", "valid longer than one cycle", 1, 0);
         if (frame_o) frames_seen++;
         if (bit_clk_o && !prev_bclk) bitclk_rises++;
         prev_valid = byte_valid_o;
         prev_bclk  = bit_clk_o;
      end
   end

   // model of R2, R6, R7, R9: frame start decision on a sync edge
   task automatic model_fsc();
      bit start;
      start = m_modeq | m_phase;
      m_phase = ~m_phase;
      if (start) begin
         m_modeq  = nibble_mode_i;
         m_mode   = nibble_mode_i;
         m_active = 1'b1;
         m_slot = 0; m_bit = 0; m_sr = 0;
         m_starts++;
      end
   endtask

   // model of R4, R5, R6, R8: bit accumulation and byte emission
   task automatic model_bit(input bit b);
      int nbits;
      if (!m_active) return;
      nbits = m_mode ? 4 : 8;
      m_sr = ((m_sr << 1) | int'(b)) & 8'hFF;
      m_bit++;
      if (m_bit == nbits) begin
         m_bit = 0;
         if (!m_mode) begin
            exp_q.push_back(pack_ent(m_slot, m_sr, m_slot % 4));
         end else if (m_slot % 2 == 0) begin
            m_hi = m_sr & 4'hF;
         end else begin
            exp_q.push_back(pack_ent(m_slot / 2, (m_hi << 4) | (m_sr & 4'hF), (m_slot / 2) % 4));
         end
         m_sr = 0;
         m_slot++;
         if (m_slot == 24) m_active = 1'b0;
      end
   endtask

   task automatic half(input logic v);
      dcl_i = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic drive_frame(input logic [95:0] bits, input int nbits, input bit with_fsc);
      for (int i = 0; i < nbits; i++) begin
         dd_i = bits[95-i];
         if (i == 0 && with_fsc) begin
            fsc_i = 1'b1;
            model_fsc();
         end
         half(1'b0);
         half(1'b1);
         fsc_i = 1'b0;
         half(1'b0);
         half(1'b1);
         model_bit(bits[95-i]);
      end
   endtask

   function automatic logic [95:0] rand_frame();
      return {$urandom, $urandom, $urandom};
   endfunction

   task automatic compare(input string req);
      repeat (12) @(negedge clk);
      chk(act_q.size() == exp_q.size(), req, "byte count", act_q.size(), exp_q.size());
      for (int i = 0; i < act_q.size() && i < exp_q.size(); i++)
         chk(act_q[i] == exp_q[i], req, "slot/data/kind entry", act_q[i], exp_q[i]);
      chk(frames_seen == m_starts, "R10", "frame strobe count", frames_seen, m_starts);
      act_q.delete();
      exp_q.delete();
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog", "run did not complete", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'h1A0D));
      m_phase = 0; m_modeq = 0; m_active = 0; m_mode = 0; m_starts = 0;
      rst_n = 1'b0; dcl_i = 1'b0; fsc_i = 1'b0; dd_i = 1'b0; nibble_mode_i = 1'b0;
      repeat (5) @(negedge clk);
      chk(!byte_valid_o && !frame_o && !bit_clk_o, "R1", "outputs in reset",
          {byte_valid_o, frame_o, bit_clk_o}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!byte_valid_o && !frame_o && !bit_clk_o, "R1", "outputs after reset",
          {byte_valid_o, frame_o, bit_clk_o}, 0);

      // R2: first sync edge after reset starts nothing
      drive_frame(rand_frame(), 96, 1'b1);
      repeat (12) @(negedge clk);
      chk(frames_seen == 0, "R2", "no frame on first sync", frames_seen, 0);
      chk(act_q.size() == 0, "R2", "no bytes before start", act_q.size(), 0);
      compare("R2");

      // R3, R4, R5: byte-mode divided frame with directed MSB-first pattern
      bitclk_rises = 0;
      drive_frame(96'h80_01_A5_5A_FF_00_7E_81_C3_3C_0F_F0, 96, 1'b1);
      drive_frame(rand_frame(), 96, 1'b1);
      compare("R4");
      chk(bitclk_rises == 192, "R3", "bit clock rises per byte frame", bitclk_rises, 192);

      // R8: bits after the last slot are ignored
      drive_frame(rand_frame(), 96, 1'b0);
      repeat (12) @(negedge clk);
      chk(act_q.size() == 0, "R8", "bytes after frame end", act_q.size(), 0);
      compare("R8");

      // R7: mode flipped inside a byte frame takes effect only at next start
      drive_frame(rand_frame(), 96, 1'b1);
      nibble_mode_i = 1'b1;
      drive_frame(rand_frame(), 96, 1'b1);
      compare("R7");
      drive_frame(96'h12_34_56_78_9A_BC_DE_F0_0F_1E_2D_3C, 96, 1'b1);
      compare("R6");

      // R9: restart in the middle of a nibble frame
      drive_frame(rand_frame(), 42, 1'b1);
      drive_frame(rand_frame(), 96, 1'b1);
      compare("R9");

      // R7: back to byte mode
      nibble_mode_i = 1'b0;
      drive_frame(rand_frame(), 96, 1'b1);
      drive_frame(rand_frame(), 96, 1'b1);
      drive_frame(rand_frame(), 96, 1'b1);
      compare("R7");

      // constrained random mix (R4, R6, R9)
      for (int k = 0; k < 8; k++) begin
         int nb;
         bit fs;
         nibble_mode_i = 1'($urandom % 2);
         fs = ($urandom % 4) != 0;
         nb = ($urandom % 5 == 0) ? 20 + int'($urandom % 70) : 96;
         drive_frame(rand_frame(), nb, fs);
         compare("R6");
      end

      finish_run();
   end
endmodule